// File: doc/BRIEF.md
# Toggle-to-Return-to-Zero Handshake Bridge

This block joins a sender that signals with transitions to a receiver that signals with levels. The sender puts a data word on its bus and then flips its request wire; either direction of the flip means one new word. The bridge answers each flip with one flip of its own acknowledge wire. On the receiver side the bridge runs a full return-to-zero cycle for every word. Its request goes high, the receiver acknowledges high, the request drops, and the acknowledge drops.

The bridge samples every handshake wire on one system clock and keeps a copy of the last request level it accepted. When the live request differs from that copy, a new word is waiting. The word is latched on the same clock edge, and the level request is raised on the next edge. The sender's acknowledge flips only once the receiver has fully returned to zero. This keeps the held word safe until the transfer is finished. A sender that flips its request again before it has been acknowledged sets a sticky error flag. Any synchronizers for the incoming wires sit outside this block.

Top module: `hs_toggle_to_rtz_bridge`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `tog_ack_o`, `lvl_req_o`, `proto_err_o` and `lvl_data_o` are all 0. The stored request copy is 0, so a low `tog_req_i` means no word is pending.
- R2: A change of `tog_req_i` in either direction, first sampled at clock edge N while the bridge is idle, makes `lvl_req_o` go high after edge N+1 and not before.
- R3: `lvl_data_o` takes the value of `tog_data_i` sampled at edge N. It stays unchanged while `lvl_req_o` is high and until the next accepted word.
- R4: `lvl_req_o` stays high until `lvl_ack_i` is sampled high. It goes low on the edge after that sample.
- R5: `tog_ack_o` flips exactly once per transfer. The flip happens only when `lvl_req_o` is already low and `lvl_ack_i` has been sampled low.
- R6: A change of `tog_data_i` without a change of `tog_req_i` has no effect. `lvl_data_o`, `lvl_req_o` and `tog_ack_o` all keep their values.
- R7: A change of `tog_req_i` while a transfer is still in progress (not yet acknowledged on `tog_ack_o`) sets `proto_err_o` to 1. It then stays 1 until reset.
- R8: A request change that raised the error is not lost. It is delivered as the next transfer, with the word present when the bridge returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tog_req_i | input | 1 | Transition-signalled request from the sender |
| tog_data_i | input | DATA_W | Data word from the sender |
| tog_ack_o | output | 1 | Transition-signalled acknowledge to the sender |
| lvl_req_o | output | 1 | Return-to-zero request to the receiver |
| lvl_data_o | output | DATA_W | Latched data word for the receiver |
| lvl_ack_i | input | 1 | Return-to-zero acknowledge from the receiver |
| proto_err_o | output | 1 | Sticky flag for a sender protocol violation |

## Verification
The checker tests four properties on every cycle:
- the latched word is stable while the level request is high;
- the level request is held until the acknowledge arrives and released one edge later;
- the sender's acknowledge flips only after the level side has returned to zero;
- the error flag never clears once set.

Other behaviour is shown only by the bench scenarios:
- the two-edge latency from a request flip of either polarity;
- that each word reaches the receiver in order with the right value;
- that data changes without a request flip are ignored;
- that an early flip raises the error and is still delivered afterwards.

// File: rtl/hs_toggle_to_rtz_bridge.sv
module hs_toggle_to_rtz_bridge #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tog_req_i,
  input  logic [DATA_W-1:0] tog_data_i,
  output logic              tog_ack_o,
  output logic              lvl_req_o,
  output logic [DATA_W-1:0] lvl_data_o,
  input  logic              lvl_ack_i,
  output logic              proto_err_o
);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_HOLD, S_DROP} state_t;

  state_t st;
  logic   req_seen;
  logic   new_evt;

  assign new_evt = tog_req_i ^ req_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      req_seen    <= 1'b0;
      tog_ack_o   <= 1'b0;
      lvl_req_o   <= 1'b0;
      lvl_data_o  <= '0;
      proto_err_o <= 1'b0;
    end else begin
      if (st != S_IDLE && new_evt)
        proto_err_o <= 1'b1;
      case (st)
        S_IDLE: if (new_evt) begin
          lvl_data_o <= tog_data_i;
          req_seen   <= tog_req_i;
          st         <= S_LOAD;
        end
        S_LOAD: begin
          lvl_req_o <= 1'b1;
          st        <= S_HOLD;
        end
        S_HOLD: if (lvl_ack_i) begin
          lvl_req_o <= 1'b0;
          st        <= S_DROP;
        end
        S_DROP: if (!lvl_ack_i) begin
          tog_ack_o <= ~tog_ack_o;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/hs_toggle_to_rtz_bridge_chk.sv
module hs_toggle_to_rtz_bridge_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tog_ack_o,
  input logic              lvl_req_o,
  input logic [DATA_W-1:0] lvl_data_o,
  input logic              lvl_ack_i,
  input logic              proto_err_o
);

  assert_data_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_req_o |=> $stable(lvl_data_o));

  assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_req_o && !lvl_ack_i) |=> lvl_req_o);

  assert_req_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_req_o && lvl_ack_i) |=> !lvl_req_o);

  assert_ack_after_rtz_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tog_ack_o != $past(tog_ack_o)) |-> (!lvl_req_o && !$past(lvl_ack_i)));

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err_o |=> proto_err_o);

endmodule

bind hs_toggle_to_rtz_bridge hs_toggle_to_rtz_bridge_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tog_ack_o(tog_ack_o), .lvl_req_o(lvl_req_o),
  .lvl_data_o(lvl_data_o), .lvl_ack_i(lvl_ack_i), .proto_err_o(proto_err_o)
);

// File: tb/hs_toggle_to_rtz_bridge_tb_top.sv
module hs_toggle_to_rtz_bridge_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tog_req_i = 1'b0;
  logic [W-1:0] tog_data_i = '0;
  logic         tog_ack_o;
  logic         lvl_req_o;
  logic [W-1:0] lvl_data_o;
  logic         lvl_ack_i = 1'b0;
  logic         proto_err_o;

  int checks = 0;
  int errors = 0;
  int delivered = 0;
  logic [W-1:0] exp_q[$];

  always #10 clk = ~clk;

  hs_toggle_to_rtz_bridge #(.DATA_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .tog_req_i(tog_req_i), .tog_data_i(tog_data_i),
    .tog_ack_o(tog_ack_o), .lvl_req_o(lvl_req_o), .lvl_data_o(lvl_data_o),
    .lvl_ack_i(lvl_ack_i), .proto_err_o(proto_err_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // receiver model and scoreboard monitor
  initial begin
    int dly = 1;
    forever begin
      @(negedge clk);
      if (rst_n && lvl_req_o && !lvl_ack_i) begin
        if (exp_q.size() == 0)
          chk(1'b0, "R3 unexpected word", {16'h0, lvl_data_o}, 32'h0);
        else begin
          logic [W-1:0] e;
          e = exp_q.pop_front();
          chk(lvl_data_o == e, "R3 delivered word", {16'h0, lvl_data_o}, {16'h0, e});
        end
        delivered++;
        repeat (dly) @(negedge clk);
        lvl_ack_i = 1'b1;
        while (lvl_req_o) @(negedge clk);
        lvl_ack_i = 1'b0;
        dly = (dly % 4) + 1;
      end
    end
  end

  task automatic wait_acks(input int n);
    logic a;
    a = tog_ack_o;
    for (int i = 0; i < n; i++) begin
      while (tog_ack_o == a) @(negedge clk);
      chk(!lvl_req_o && !lvl_ack_i, "R5 ack after return to zero",
          {30'h0, lvl_req_o, lvl_ack_i}, 32'h0);
      a = tog_ack_o;
    end
    repeat (3) @(negedge clk);
    chk(tog_ack_o == a, "R5 single ack flip", {31'h0, tog_ack_o}, {31'h0, a});
  endtask

  task automatic send(input logic [W-1:0] d);
    @(negedge clk);
    tog_data_i = d;
    tog_req_i  = ~tog_req_i;
    exp_q.push_back(d);
    @(negedge clk);
    chk(lvl_req_o == 1'b0, "R2 request not yet raised", {31'h0, lvl_req_o}, 32'h0);
    tog_data_i = ~d;
    @(negedge clk);
    chk(lvl_req_o == 1'b1, "R2 request raised after two edges", {31'h0, lvl_req_o}, 32'h1);
    chk(lvl_data_o == d, "R3 word latched at detect edge", {16'h0, lvl_data_o}, {16'h0, d});
    wait_acks(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] hold;
    repeat (3) @(negedge clk);
    chk({tog_ack_o, lvl_req_o, proto_err_o} == 3'b000 && lvl_data_o == '0, "R1 reset outputs",
        {13'h0, tog_ack_o, lvl_req_o, proto_err_o, lvl_data_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({tog_ack_o, lvl_req_o, proto_err_o} == 3'b000, "R1 idle after reset",
        {29'h0, tog_ack_o, lvl_req_o, proto_err_o}, 32'h0);

    send(16'hA5C3);   // rising request flip (R2)
    send(16'h1234);   // falling request flip (R2)
    send(16'hFFFF);
    send(16'h0001);
    chk(proto_err_o == 1'b0, "R7 no error on clean traffic", {31'h0, proto_err_o}, 32'h0);

    // R6: data wiggle without a request flip
    hold = lvl_data_o;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      tog_data_i = 16'h5A00 + 16'(i);
    end
    repeat (3) @(negedge clk);
    chk(lvl_data_o == hold, "R6 data ignored without flip", {16'h0, lvl_data_o}, {16'h0, hold});
    chk(!lvl_req_o, "R6 no request without flip", {31'h0, lvl_req_o}, 32'h0);
    chk(tog_ack_o == 1'b0, "R6 ack unchanged", {31'h0, tog_ack_o}, 32'h0);

    // R7/R8: early second flip
    @(negedge clk);
    tog_data_i = 16'hBEEF;
    tog_req_i  = ~tog_req_i;
    exp_q.push_back(16'hBEEF);
    @(negedge clk);
    tog_data_i = 16'hCAFE;
    tog_req_i  = ~tog_req_i;
    exp_q.push_back(16'hCAFE);
    @(negedge clk);
    @(negedge clk);
    chk(proto_err_o == 1'b1, "R7 early flip flagged", {31'h0, proto_err_o}, 32'h1);
    wait_acks(2);
    chk(exp_q.size() == 0, "R8 early word delivered", exp_q.size(), 32'h0);
    chk(proto_err_o == 1'b1, "R7 error stays set", {31'h0, proto_err_o}, 32'h1);
    chk(delivered == 6, "R5 one transfer per flip", delivered, 32'd6);

    @(negedge clk);
    rst_n = 1'b0;
    tog_req_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(proto_err_o == 1'b0, "R7 reset clears error", {31'h0, proto_err_o}, 32'h0);
    chk({tog_ack_o, lvl_req_o} == 2'b00, "R1 outputs low after second reset",
        {30'h0, tog_ack_o, lvl_req_o}, 32'h0);
    send(16'h7E81);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule